// File: doc/BRIEF.md
# Row Idle Timeout Tuner

This block picks how long one DRAM bank keeps an idle row open before it is closed. It watches the activate (ACT) and column access (CAS) commands sent to the bank. For each of seven candidate timeouts it works out whether the command would have been a row hit, a row miss or a row conflict under that candidate. The projected hit and conflict counts build up over a window of requests. At the end of each window the block compares every candidate with the timeout now in use and publishes the winner, but only when the projected gain is clear enough.

A memory controller drives one command strobe per command, with its type, the row address and a free-running cycle count. It reads back the timeout, in cycles, for its own row-closure timer. Issuing commands and running the timer are not part of this block.

Top module: `row_idle_tuner`

## Requirements
- R1: Candidates have indices 0 to 6 and timeouts of 50, 100, 150, 200, 300, 400 and 800 cycles. After a synchronous reset the selected index is 0, so the published timeout is 50. The last CAS time and the previous row are both 0 after reset.
- R2: An ACT to a row different from the previous ACT's row is projected as a conflict for a candidate when (now − last CAS time) < timeout + TRP, and as a miss otherwise. It is never projected as a hit.
- R3: An ACT to the same row as the previous ACT is projected as a hit for a candidate when (now − last CAS time) < timeout, and as a miss otherwise. It is never projected as a conflict.
- R4: A CAS that follows an ACT (with no CAS between them) adds that ACT's projection to the counters. A CAS with no ACT since the previous CAS counts as a hit for every candidate whose index is at or above the selected one. For shorter candidates it counts as a hit only when (now − last CAS time) < timeout. Every CAS sets the last CAS time to now.
- R5: Both ACT and CAS count as requests. After every EVAL_PERIOD requests, the evaluation runs in the following cycle. The published timeout changes at no other time.
- R6: In the evaluation, score[i] = (hits[i] − hits[cur]) − (conflicts[i] − conflicts[cur]). The best candidate has the highest score; a tie goes to the lowest index.
- R7: The selection moves to the best candidate only when best score × 100 > PCT × hits[cur]. Otherwise it stays where it is.
- R8: All counters clear in the evaluation cycle. A CAS in that same cycle is counted into the new window, and any command in that cycle counts as a request of the new window.
- R9: Hit and conflict counters saturate at 2^CNT_W − 1 instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | A command is issued to the bank this cycle |
| cmd_cas | input | 1 | 1 = column access (CAS), 0 = row activate (ACT) |
| cmd_row | input | 16 | Row address of an ACT |
| cycle_now | input | 32 | Free-running cycle count |
| timeout_cycles | output | 10 | Idle timeout currently published, in cycles |
| timeout_sel | output | 3 | Index of the published candidate |

## Verification
The block's only outputs are the timeout and its index, and they move only in the cycle after a window closes. A corrupted projection bit, counter or last-CAS time therefore stays hidden for up to EVAL_PERIOD requests. It then shows up as a wrong choice at the next window boundary, and only if it changes that window's decision. The stimulus is built as windows in which a single rule decides the outcome: gap lengths around the candidate limits, saturation of the counters, a gain just below the threshold, and a CAS placed exactly in the evaluation cycle. A fault in that rule then shows up as a wrong timeout one cycle after the window ends.

// File: rtl/rit_pkg.sv
package rit_pkg;

    localparam int NCAND  = 7;
    localparam int IDX_W  = 3;
    localparam int TO_W   = 10;
    localparam int ROW_W  = 16;
    localparam int TIME_W = 32;

    typedef logic [IDX_W-1:0] cand_idx_t;
    typedef logic [NCAND-1:0] cand_vec_t;

    // projected outcome per candidate; a clear bit in both vectors means miss
    typedef struct packed {
        cand_vec_t hit;
        cand_vec_t conf;
    } outcome_t;

    function automatic logic [TO_W-1:0] cand_timeout(input cand_idx_t idx);
        case (idx)
            3'd0:    return 10'd50;
            3'd1:    return 10'd100;
            3'd2:    return 10'd150;
            3'd3:    return 10'd200;
            3'd4:    return 10'd300;
            3'd5:    return 10'd400;
            default: return 10'd800;
        endcase
    endfunction

endpackage

// File: rtl/rit_project.sv
module rit_project
    import rit_pkg::*;
#(
    parameter int TRP = 10
) (
    input  logic [TIME_W-1:0] now,
    input  logic [TIME_W-1:0] last_cas,
    input  logic [ROW_W-1:0]  row,
    input  logic [ROW_W-1:0]  prev_row,
    input  cand_idx_t         cur_idx,
    input  outcome_t          pend,
    input  logic              pend_valid,
    output outcome_t          act_proj,
    output outcome_t          cas_proj
);
    localparam logic [TIME_W-1:0] TRP_T = TIME_W'(TRP);

    logic [TIME_W-1:0] gap;
    cand_vec_t         same_hit;
    cand_vec_t         diff_conf;
    cand_vec_t         live_hit;
    logic              same_row;

    assign gap      = now - last_cas;
    assign same_row = (row == prev_row);

    for (genvar g = 0; g < NCAND; g++) begin : g_cand
        localparam logic [TIME_W-1:0] TO = TIME_W'(cand_timeout(cand_idx_t'(g)));
        assign same_hit[g]  = (gap < TO);
        assign diff_conf[g] = (gap < TO + TRP_T);
        assign live_hit[g]  = (cand_idx_t'(g) >= cur_idx) || (gap < TO);
    end

    always_comb begin
        act_proj.hit  = same_row ? same_hit : '0;
        act_proj.conf = same_row ? '0 : diff_conf;
        if (pend_valid) begin
            cas_proj = pend;
        end else begin
            cas_proj.hit  = live_hit;
            cas_proj.conf = '0;
        end
    end

endmodule

// File: rtl/rit_counters.sv
module rit_counters
    import rit_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        clr,
    input  logic                        inc_en,
    input  outcome_t                    inc,
    output logic [NCAND-1:0][CNT_W-1:0] hit_cnt,
    output logic [NCAND-1:0][CNT_W-1:0] conf_cnt
);
    localparam logic [CNT_W-1:0] MAXV = '1;

    for (genvar g = 0; g < NCAND; g++) begin : g_cnt
        logic [CNT_W-1:0] hq, cq, hb, cb;

        assign hb = clr ? '0 : hq;
        assign cb = clr ? '0 : cq;

        always_ff @(posedge clk) begin
            if (rst) begin
                hq <= '0;
                cq <= '0;
            end else if (clr || inc_en) begin
                hq <= (inc_en && inc.hit[g]  && hb != MAXV) ? hb + 1'b1 : hb;
                cq <= (inc_en && inc.conf[g] && cb != MAXV) ? cb + 1'b1 : cb;
            end
        end

        assign hit_cnt[g]  = hq;
        assign conf_cnt[g] = cq;

        AST_CNT_SAT: assert property (@(posedge clk) disable iff (rst)
            (!clr && hq == MAXV) |=> (hq == MAXV))
            else $error("hit counter left saturation"); // R9

        AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (rst)
            (clr && !inc_en) |=> (hq == '0 && cq == '0))
            else $error("counters not cleared at evaluation"); // R8
    end

endmodule

// File: rtl/rit_select.sv
module rit_select
    import rit_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int PCT   = 3
) (
    input  logic [NCAND-1:0][CNT_W-1:0] hit_cnt,
    input  logic [NCAND-1:0][CNT_W-1:0] conf_cnt,
    input  cand_idx_t                   cur_idx,
    output cand_idx_t                   next_idx
);
    always_comb begin : sel_proc
        int        hc, cc, s, best_s;
        cand_idx_t best;
        hc     = int'(hit_cnt[cur_idx]);
        cc     = int'(conf_cnt[cur_idx]);
        best_s = (int'(hit_cnt[0]) - hc) - (int'(conf_cnt[0]) - cc);
        best   = '0;
        for (int i = 1; i < NCAND; i++) begin
            s = (int'(hit_cnt[i]) - hc) - (int'(conf_cnt[i]) - cc);
            if (s > best_s) begin
                best_s = s;
                best   = cand_idx_t'(i);
            end
        end
        if (best_s * 100 > PCT * hc) next_idx = best;
        else                         next_idx = cur_idx;
    end

endmodule

// File: rtl/row_idle_tuner.sv
module row_idle_tuner
    import rit_pkg::*;
#(
    parameter int TRP         = 10,
    parameter int EVAL_PERIOD = 30000,
    parameter int CNT_W       = 16,
    parameter int PCT         = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic              cmd_cas,
    input  logic [ROW_W-1:0]  cmd_row,
    input  logic [TIME_W-1:0] cycle_now,
    output logic [TO_W-1:0]   timeout_cycles,
    output logic [IDX_W-1:0]  timeout_sel
);
    localparam int RC_W = $clog2(EVAL_PERIOD + 1);
    localparam logic [RC_W-1:0] RC_LAST = RC_W'(EVAL_PERIOD - 1);

    logic [ROW_W-1:0]  prev_row;
    logic [TIME_W-1:0] last_cas;
    outcome_t          pend;
    logic              pend_valid;
    cand_idx_t         cur_idx;
    cand_idx_t         next_idx;
    logic [RC_W-1:0]   req_cnt;
    logic              eval_go;
    outcome_t          act_proj;
    outcome_t          cas_proj;
    logic [NCAND-1:0][CNT_W-1:0] hit_cnt;
    logic [NCAND-1:0][CNT_W-1:0] conf_cnt;

    rit_project #(.TRP(TRP)) u_project (
        .now        (cycle_now),
        .last_cas   (last_cas),
        .row        (cmd_row),
        .prev_row   (prev_row),
        .cur_idx    (cur_idx),
        .pend       (pend),
        .pend_valid (pend_valid),
        .act_proj   (act_proj),
        .cas_proj   (cas_proj)
    );

    rit_counters #(.CNT_W(CNT_W)) u_counters (
        .clk      (clk),
        .rst      (rst),
        .clr      (eval_go),
        .inc_en   (cmd_valid && cmd_cas),
        .inc      (cas_proj),
        .hit_cnt  (hit_cnt),
        .conf_cnt (conf_cnt)
    );

    rit_select #(.CNT_W(CNT_W), .PCT(PCT)) u_select (
        .hit_cnt  (hit_cnt),
        .conf_cnt (conf_cnt),
        .cur_idx  (cur_idx),
        .next_idx (next_idx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_row   <= '0;
            last_cas   <= '0;
            pend       <= '0;
            pend_valid <= 1'b0;
            cur_idx    <= '0;
            req_cnt    <= '0;
            eval_go    <= 1'b0;
        end else begin
            eval_go <= 1'b0;
            if (cmd_valid) begin
                if (req_cnt == RC_LAST) begin
                    req_cnt <= '0;
                    eval_go <= 1'b1;
                end else begin
                    req_cnt <= req_cnt + 1'b1;
                end
                if (cmd_cas) begin
                    last_cas   <= cycle_now;
                    pend_valid <= 1'b0;
                end else begin
                    prev_row   <= cmd_row;
                    pend       <= act_proj;
                    pend_valid <= 1'b1;
                end
            end
            if (eval_go) cur_idx <= next_idx;
        end
    end

    assign timeout_cycles = cand_timeout(cur_idx);
    assign timeout_sel    = cur_idx;

    AST_TIMEOUT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !eval_go |=> $stable(cur_idx))
        else $error("timeout moved outside an evaluation"); // R5

    AST_EVAL_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (rst)
        eval_go |-> $past(cmd_valid))
        else $error("evaluation without a closing request"); // R5

    AST_PROJ_EXCL: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_cas) |-> ((cas_proj.hit & cas_proj.conf) == '0))
        else $error("hit and conflict projected together"); // R2

    AST_SEL_RANGE: assert property (@(posedge clk) disable iff (rst)
        cur_idx < cand_idx_t'(NCAND))
        else $error("selected candidate out of range"); // R6

endmodule

// File: tb/row_idle_tuner_test.sv
`timescale 1ns/1ps
module row_idle_tuner_test;
    localparam int P     = 80;
    localparam int CW    = 6;
    localparam int TRPV  = 10;
    localparam int PCTV  = 3;
    localparam int MAXC  = 63;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic        cmd_cas = 1'b0;
    logic [15:0] cmd_row = '0;
    logic [31:0] tick = '0;
    logic [9:0]  timeout_cycles;
    logic [2:0]  timeout_sel;

    always #10 clk = ~clk;
    always @(posedge clk) tick <= tick + 1;

    row_idle_tuner #(.TRP(TRPV), .EVAL_PERIOD(P), .CNT_W(CW), .PCT(PCTV)) uut (
        .clk            (clk),
        .rst            (rst),
        .cmd_valid      (cmd_valid),
        .cmd_cas        (cmd_cas),
        .cmd_row        (cmd_row),
        .cycle_now      (tick),
        .timeout_cycles (timeout_cycles),
        .timeout_sel    (timeout_sel)
    );

    int tos [7] = '{50, 100, 150, 200, 300, 400, 800};
    int checks = 0;
    int errors = 0;
    bit done = 0;
    string phase = "R1 reset";
    logic [31:0] b_last = '0;

    // behavioural reference
    int m_hit [7];
    int m_conf [7];
    bit ph [7];
    bit pc [7];
    int m_prev, m_cur, m_cnt, oc, nc, hc, cc, s, bs, bi;
    bit m_eval, ev, m_pend_v, h, c;
    logic [31:0] m_last;
    longint gp;

    always @(posedge clk) begin
        if (rst) begin
            m_cur = 0; m_cnt = 0; m_eval = 0; m_pend_v = 0; m_last = '0; m_prev = 0;
            for (int i = 0; i < 7; i++) begin m_hit[i] = 0; m_conf[i] = 0; ph[i] = 0; pc[i] = 0; end
        end else begin
            oc = m_cur; nc = m_cur;
            if (m_eval) begin
                hc = m_hit[oc]; cc = m_conf[oc]; bs = -1000000; bi = 0;
                for (int i = 0; i < 7; i++) begin
                    s = (m_hit[i] - hc) - (m_conf[i] - cc);
                    if (s > bs) begin bs = s; bi = i; end
                end
                if (bs * 100 > PCTV * hc) nc = bi;
                for (int i = 0; i < 7; i++) begin m_hit[i] = 0; m_conf[i] = 0; end
            end
            ev = 0;
            if (cmd_valid) begin
                gp = longint'(tick - m_last);
                if (!cmd_cas) begin
                    for (int i = 0; i < 7; i++) begin
                        if (int'(cmd_row) == m_prev) begin ph[i] = (gp < tos[i]); pc[i] = 0; end
                        else begin ph[i] = 0; pc[i] = (gp < tos[i] + TRPV); end
                    end
                    m_prev = int'(cmd_row);
                    m_pend_v = 1;
                end else begin
                    for (int i = 0; i < 7; i++) begin
                        if (m_pend_v) begin h = ph[i]; c = pc[i]; end
                        else begin h = (i >= oc) || (gp < tos[i]); c = 0; end
                        if (h && m_hit[i] < MAXC) m_hit[i]++;
                        if (c && m_conf[i] < MAXC) m_conf[i]++;
                    end
                    m_last = tick;
                    m_pend_v = 0;
                end
                m_cnt++;
                if (m_cnt == P) begin m_cnt = 0; ev = 1; end
            end
            m_eval = ev;
            m_cur = nc;
        end
    end

    // per-cycle comparison against the reference
    always @(negedge clk) begin
        if (!rst && !done) begin
            checks++;
            if (timeout_cycles !== 10'(tos[m_cur]) || timeout_sel !== 3'(m_cur)) begin
                errors++;
                $display("FAIL %s: timeout %0d sel %0d, expected %0d sel %0d",
                         phase, timeout_cycles, timeout_sel, tos[m_cur], m_cur);
            end
        end
    end

    task automatic expect_to(input int exp, input string tag);
        checks++;
        if (timeout_cycles !== 10'(exp)) begin
            errors++;
            $display("FAIL %s: timeout %0d, expected %0d", tag, timeout_cycles, exp);
        end
    endtask

    task automatic drive(input bit cas, input int row);
        cmd_valid = 1'b1;
        cmd_cas   = cas;
        cmd_row   = 16'(row);
        if (cas) b_last = tick;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic wait_tick(input logic [31:0] t);
        while (tick < t) @(negedge clk);
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    initial begin
        #(20 * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        checks++;
        if (timeout_cycles !== 10'd50 || timeout_sel !== 3'd0) begin
            errors++;
            $display("FAIL R1: timeout %0d sel %0d, expected 50 sel 0", timeout_cycles, timeout_sel);
        end

        // same-row reopen after 120 idle cycles: hits for 150 and up
        phase = "R3 R5 R6 same-row reopen";
        for (int k = 0; k < 40; k++) begin
            wait_tick(b_last + 120);
            drive(0, 0);
            drive(1, 0);
        end
        settle();
        expect_to(150, "R6 best lowest index");

        // 200 gains 10 hits but saturates; shorter ones stay at 60
        phase = "R9 saturation";
        for (int k = 0; k < 10; k++) begin
            wait_tick(b_last + 170);
            drive(0, 0);
            drive(1, 0);
        end
        for (int k = 0; k < 60; k++) begin
            wait_tick(b_last + 5);
            drive(1, 0);
        end
        settle();
        expect_to(200, "R9 saturated gain");

        // row changes after 120 idle cycles: conflicts for 150 and up
        phase = "R2 conflict projection";
        for (int k = 0; k < 40; k++) begin
            wait_tick(b_last + 120);
            drive(0, 1 + (k % 2));
            drive(1, 0);
        end
        settle();
        expect_to(50, "R2 conflicts favour short timeout");

        // gain of one hit against 40 hits stays below threshold
        phase = "R7 threshold";
        wait_tick(b_last + 70);
        drive(0, 2);
        drive(1, 2);
        for (int k = 0; k < 40; k++) begin
            wait_tick(b_last + 5);
            drive(1, 2);
        end
        for (int k = 0; k < 38; k++) drive(0, 3 + (k % 2));
        settle();
        expect_to(50, "R7 below threshold");

        // CAS in the evaluation cycle counts into the next window
        phase = "R8 eval-cycle command";
        drive(1, 0);
        for (int k = 0; k < 78; k++) drive(0, 5 + (k % 2));
        drive(0, 6);
        drive(1, 0);
        for (int k = 0; k < 79; k++) drive(0, 7 + (k % 2));
        settle();
        expect_to(100, "R8 carried CAS");

        // long-gap CAS with no ACT: index >= current keeps its hit
        phase = "R4 kept hits";
        for (int k = 0; k < 80; k++) begin
            wait_tick(b_last + 300);
            drive(1, 0);
        end
        settle();
        expect_to(100, "R4 longer candidates keep hits");

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule